// File: doc/BRIEF.md
# Indirect Interrupt Controller Register File

This block holds the configuration state of an I/O interrupt controller: a controller identifier, a fixed version word and a table of routing entries, one 64-bit entry per interrupt pin. A host reaches all of it through two 32-bit bus registers. One is an index register, and the other is a data window that reads or writes whichever internal register the index names. Each routing entry shows up in the index space as two 32-bit halves.

Two bits of each entry are status that software must not alter. These are the remote-IRR flag and the delivery-status flag. Bus writes leave them as they are. A neighbouring delivery block sets and clears remote-IRR through per-pin side inputs. The whole table is driven out in parallel so that the delivery logic can use it. When a table write changes any bit other than the mask or polarity bits, the block raises a one-cycle recalculation pulse. Downstream logic uses this pulse to rebuild its trigger-mode view.

Top module: `intc_window_regs`

## Requirements
- R1: After reset the index register and the identifier read as zero, every entry equals 0x0001000000010000 (all pins masked), and `recalc` is low.
- R2: Only accesses with `bus_size` equal to 4 at byte offset 0x00 (index) or 0x10 (window) take effect. Any other size or offset reads zero and leaves all state unchanged on a write.
- R3: The index register stores all 32 bits written at offset 0x00 and reads them back. A window access uses only bits 7:0 of the index.
- R4: A window write to index 0 keeps only data bits 31:24 as the identifier. Reads of index 0 and of index 2 both return the identifier in bits 31:24, with zeros below.
- R5: Index 1 reads the version word, which is (entries − 1) in bits 23:16 ORed with 0x11, giving 0x001F0011 by default. Writes to index 1 and to index 2 change nothing.
- R6: Entry p is reached at index 0x10 + 2p for bits 31:0 and at index 0x11 + 2p for bits 63:32, and each half reads back what it holds.
- R7: A window write to an entry half replaces every bit of that half except bit 14 (remote-IRR) and bit 12 (delivery status), which keep their previous values.
- R8: `rirr_set[p]` sets bit 14 of entry p and `rirr_clr[p]` clears it on the next edge. If both are high in the same cycle, set wins.
- R9: `recalc` is high for exactly the cycle after a table write that changed any entry bit other than bit 16 (mask) and bit 13 (polarity). It stays low otherwise.
- R10: Window reads of index 3 to 0x0F and of indexes at or above 0x10 + 2·entries return zero, and writes there change nothing.
- R11: The `entries` output always shows the current content of every table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_offset | input | 8 | Byte offset of the access |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| rirr_set | input | ENTRIES | Per-pin set of remote-IRR |
| rirr_clr | input | ENTRIES | Per-pin clear of remote-IRR |
| entries | output | ENTRIES×64 | Current table content |
| recalc | output | 1 | Trigger-mode recalculation pulse |

## Verification
The bench targets the protected bits. It writes ones over remote-IRR and delivery status while remote-IRR is set, cleared, and set and cleared in the same cycle. A design that merged these bits wrongly would show them toggling under bus writes, or would let a clear beat a set.

It separates writes that change only the mask or polarity bits from writes that change any other bit, and it also rewrites identical values. A wrong filter on the changed bits would either miss a `recalc` pulse or add one that should not be there.

It probes the edges of the index space: the last entry's halves, the first index past the table, the gap below the table, and an index whose upper bits are set. It also sends 2-byte and 8-byte accesses and accesses at stray offsets. A decoder that was off by one, or that used more than the low index byte, would return data or take a write where zero and no effect are required.

// File: rtl/intc_window_regs.sv
module intc_window_regs #(
  parameter int ENTRIES = 32,
  parameter int TBL_BASE = 16,
  parameter logic [7:0] VER_CODE = 8'h11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [7:0]                bus_offset,
  input  logic [3:0]                bus_size,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [ENTRIES-1:0]        rirr_set,
  input  logic [ENTRIES-1:0]        rirr_clr,
  output logic [ENTRIES-1:0][63:0]  entries,
  output logic                      recalc
);
  localparam int PIN_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int TBL_END = TBL_BASE + 2 * ENTRIES;
  localparam int RIRR_BIT = 14;
  localparam int DSTAT_BIT = 12;
  localparam int MASK_BIT = 16;
  localparam int POL_BIT = 13;
  localparam logic [31:0] RO_BITS = (32'd1 << RIRR_BIT) | (32'd1 << DSTAT_BIT);
  localparam logic [31:0] QUIET_BITS = (32'd1 << MASK_BIT) | (32'd1 << POL_BIT);
  localparam logic [63:0] RST_ENTRY = 64'h0001_0000_0001_0000;
  localparam logic [31:0] VER_WORD = (32'(ENTRIES - 1) << 16) | {24'd0, VER_CODE};

  logic [31:0] sel_q;
  logic [7:0]  id_q;
  logic        recalc_q;
  logic [ENTRIES-1:0][63:0] ent_q, ent_d;

  wire acc_ok  = bus_valid && bus_size == 4'd4 &&
                 (bus_offset == 8'h00 || bus_offset == 8'h10);
  wire sel_hit = acc_ok && bus_offset == 8'h00;
  wire win_hit = acc_ok && bus_offset == 8'h10;

  wire [7:0] idx = sel_q[7:0];
  wire [8:0] idx9 = {1'b0, idx};
  wire in_tbl = idx9 >= 9'(TBL_BASE) && idx9 < 9'(TBL_END);
  wire [7:0] toff = idx - 8'(TBL_BASE);
  wire [PIN_W-1:0] pin = toff[PIN_W:1];
  wire hi = toff[0];

  wire tbl_wr = win_hit && bus_write && in_tbl;
  wire id_wr  = win_hit && bus_write && idx == 8'd0;

  wire [31:0] cur_half = hi ? ent_q[pin][63:32] : ent_q[pin][31:0];
  wire [31:0] ro_half  = hi ? 32'd0 : RO_BITS;
  wire [31:0] new_half = (bus_wdata & ~ro_half) | (cur_half & ro_half);
  wire [31:0] care     = hi ? 32'hFFFF_FFFF : ~QUIET_BITS;
  wire        relevant = |((cur_half ^ new_half) & care);

  always_comb begin
    ent_d = ent_q;
    for (int i = 0; i < ENTRIES; i++) begin
      if (tbl_wr && pin == PIN_W'(i)) begin
        if (hi) ent_d[i][63:32] = new_half;
        else    ent_d[i][31:0]  = new_half;
      end
      if (rirr_clr[i]) ent_d[i][RIRR_BIT] = 1'b0;
      if (rirr_set[i]) ent_d[i][RIRR_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      id_q     <= '0;
      recalc_q <= 1'b0;
      ent_q    <= {ENTRIES{RST_ENTRY}};
    end else begin
      if (sel_hit && bus_write) sel_q <= bus_wdata;
      if (id_wr) id_q <= bus_wdata[31:24];
      recalc_q <= tbl_wr && relevant;
      ent_q    <= ent_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      if (sel_hit) bus_rdata = sel_q;
      else if (win_hit) begin
        if (idx == 8'd0 || idx == 8'd2) bus_rdata = {id_q, 24'd0};
        else if (idx == 8'd1)           bus_rdata = VER_WORD;
        else if (in_tbl)                bus_rdata = cur_half;
      end
    end
  end

  assign entries = ent_q;
  assign recalc  = recalc_q;

  logic [ENTRIES-1:0] rirr_v;
  always_comb
    for (int i = 0; i < ENTRIES; i++) rirr_v[i] = ent_q[i][RIRR_BIT];

  assert_bad_access_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && !acc_ok) |-> bus_rdata == 32'd0);

  assert_index_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hit && bus_write) |=> sel_q == $past(bus_wdata));

  assert_rirr_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rirr_v & ~$past(rirr_v))) |-> $past(|rirr_set));

  assert_recalc_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    recalc |-> $past(win_hit && bus_write));

  assert_undef_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit && bus_write && !in_tbl && idx > 8'd2 && rirr_set == '0 && rirr_clr == '0)
    |=> ($stable(ent_q) && $stable(id_q) && !recalc));
endmodule

// File: tb/sim_intc_window_regs.sv
`timescale 1ns/1ps
module sim_intc_window_regs;
  localparam int N = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 0, bus_write = 0;
  logic [7:0] bus_offset = 0;
  logic [3:0] bus_size = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [N-1:0] rirr_set = 0, rirr_clr = 0;
  logic [N-1:0][63:0] entries;
  logic recalc;

  intc_window_regs u0 (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_offset(bus_offset), .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rirr_set(rirr_set), .rirr_clr(rirr_clr), .entries(entries), .recalc(recalc));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] m_sel;
  logic [7:0]  m_id;
  logic [63:0] m_tbl [N];
  bit          m_rc;

  function automatic logic [31:0] m_read(bit v, bit w, logic [7:0] off, logic [3:0] sz);
    int ix, p;
    if (!v || w || sz != 4) return 0;
    if (off == 8'h00) return m_sel;
    if (off != 8'h10) return 0;
    ix = int'(m_sel[7:0]);
    if (ix == 0 || ix == 2) return {m_id, 24'd0};
    if (ix == 1) return 32'h001F_0011;
    if (ix >= 16 && ix < 16 + 2 * N) begin
      p = (ix - 16) / 2;
      return (ix % 2 == 1) ? m_tbl[p][63:32] : m_tbl[p][31:0];
    end
    return 0;
  endfunction

  task automatic chk(logic [63:0] got, logic [63:0] exp, string tag, string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic op(bit v, bit w, logic [7:0] off, logic [3:0] sz, logic [31:0] d,
                    logic [N-1:0] st, logic [N-1:0] cl, string tag);
    logic [63:0] nt [N];
    logic [31:0] ns, oldh, newh, ro, care;
    logic [7:0] nid;
    bit nrc;
    int ix, p;
    bus_valid = v; bus_write = w; bus_offset = off; bus_size = sz; bus_wdata = d;
    rirr_set = st; rirr_clr = cl;
    #1;
    chk(64'(bus_rdata), 64'(m_read(v, w, off, sz)), tag, "rdata");
    chk(64'(recalc), 64'(m_rc), tag, "recalc");
    for (int i = 0; i < N; i++)
      if (entries[i] !== m_tbl[i]) chk(entries[i], m_tbl[i], tag, $sformatf("entry%0d", i));
    n_cmp++;
    foreach (nt[i]) nt[i] = m_tbl[i];
    ns = m_sel; nid = m_id; nrc = 0;
    if (v && w && sz == 4) begin
      if (off == 8'h00) ns = d;
      else if (off == 8'h10) begin
        ix = int'(m_sel[7:0]);
        if (ix == 0) nid = d[31:24];
        if (ix >= 16 && ix < 16 + 2 * N) begin
          p = (ix - 16) / 2;
          if (ix % 2 == 1) begin
            oldh = m_tbl[p][63:32]; ro = 0; care = 32'hFFFF_FFFF;
          end else begin
            oldh = m_tbl[p][31:0]; ro = 32'h0000_5000; care = ~32'h0001_2000;
          end
          newh = (d & ~ro) | (oldh & ro);
          nrc = ((oldh ^ newh) & care) != 0;
          if (ix % 2 == 1) nt[p][63:32] = newh; else nt[p][31:0] = newh;
        end
      end
    end
    for (int i = 0; i < N; i++) begin
      if (cl[i]) nt[i][14] = 1'b0;
      if (st[i]) nt[i][14] = 1'b1;
    end
    @(posedge clk);
    foreach (m_tbl[i]) m_tbl[i] = nt[i];
    m_sel = ns; m_id = nid; m_rc = nrc;
    @(negedge clk);
  endtask

  task automatic wsel(logic [31:0] d, string tag);  op(1, 1, 8'h00, 4, d, 0, 0, tag); endtask
  task automatic wwin(logic [31:0] d, string tag);  op(1, 1, 8'h10, 4, d, 0, 0, tag); endtask
  task automatic rwin(string tag);                  op(1, 0, 8'h10, 4, 0, 0, 0, tag); endtask
  task automatic rsel(string tag);                  op(1, 0, 8'h00, 4, 0, 0, 0, tag); endtask
  task automatic side(logic [N-1:0] s, logic [N-1:0] c, string tag); op(0, 0, 0, 0, 0, s, c, tag); endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    m_sel = 0; m_id = 0; m_rc = 0;
    foreach (m_tbl[i]) m_tbl[i] = 64'h0001_0000_0001_0000;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    side(0, 0, "R1"); rsel("R1"); rwin("R1");
    wsel(32'h1234_5601, "R3"); rsel("R3"); rwin("R5");
    wsel(32'h0000_0001, "R5"); rwin("R5"); wwin(32'hFFFF_FFFF, "R5"); rwin("R5");
    wsel(0, "R4"); wwin(32'hABCD_EF12, "R4"); rwin("R4");
    wsel(2, "R4"); rwin("R4"); wwin(32'h5500_0000, "R5"); rwin("R5");
    wsel(0, "R4"); rwin("R4");
    op(1, 1, 8'h00, 2, 32'h0000_0010, 0, 0, "R2"); rsel("R2");
    op(1, 1, 8'h04, 4, 32'h0000_0010, 0, 0, "R2"); rsel("R2");
    op(1, 0, 8'h04, 4, 0, 0, 0, "R2"); op(1, 0, 8'h10, 8, 0, 0, 0, "R2");
    wsel(32'h10, "R2"); op(1, 1, 8'h10, 2, 32'h0, 0, 0, "R2"); rwin("R2");
    op(1, 1, 8'h14, 4, 32'h0, 0, 0, "R2"); rwin("R2");
    wwin(32'h0000_5F21, "R7"); rwin("R7"); side(0, 0, "R9");
    wsel(32'h11, "R6"); wwin(32'hFF00_0000, "R9"); rwin("R6");
    wsel(32'h10, "R9"); wwin(32'h0001_2F21, "R9"); side(0, 0, "R9");
    wwin(32'h0001_2F21, "R9"); side(0, 0, "R9");
    side(32'h1, 0, "R8"); rwin("R8");
    wwin(32'h0000_0F21, "R7"); rwin("R7");
    side(32'h1, 32'h1, "R8"); side(0, 32'h1, "R8"); rwin("R8");
    op(1, 1, 8'h10, 4, 32'h0000_4021, 32'h1, 0, "R7"); rwin("R7");
    op(1, 1, 8'h10, 4, 32'h0000_1021, 0, 32'h1, "R7"); rwin("R7");
    wsel(32'h4E, "R6"); wwin(32'h0000_00C3, "R6"); rwin("R6");
    wsel(32'h4F, "R6"); wwin(32'h0300_0000, "R6"); rwin("R6");
    wsel(32'h50, "R10"); rwin("R10"); wwin(32'hFFFF_FFFF, "R10"); rwin("R10");
    wsel(32'h0F, "R10"); rwin("R10"); wwin(32'h1, "R10");
    wsel(32'h03, "R10"); rwin("R10"); wwin(32'h1, "R10");
    wsel(32'h150, "R3"); rwin("R3"); wsel(32'hFF11, "R3"); rwin("R3");
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[2:0])
        3'd0, 3'd1: wsel({24'd0, 8'(16 + (lfsr[12:8] % 5'd31) * 2 + int'(lfsr[13]))}, "R11");
        3'd2, 3'd3: wwin(lfsr[4] ? {lfsr[31:8], 8'h00} : (lfsr ^ 32'h0001_2000), "R9");
        3'd4:       rwin("R11");
        3'd5:       side(N'(lfsr[31:16]) << lfsr[9:5], N'(lfsr[15:8]) << lfsr[7:3], "R8");
        default:    op(1, lfsr[5], 8'(lfsr[11:6] & 6'h3C), 4'(lfsr[14:12] | 3'd1), lfsr, 0, 0, "R2");
      endcase
    end
    side(0, 0, "R11");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule